// File: doc/BRIEF.md
# Iterative Age-Slot Lane-to-Pipe Matcher

This block pairs the instruction lanes of a decoded fetch block with backend issue pipes. Each lane can go to at most one pipe, and each pipe can take at most one lane. Every lane presents a valid bit, an operation-class bitmask, two source-ready bits and a sequence number. Every pipe presents a mask of the classes it supports, a ready bit, the number of free slots in its issue queue and a bypass flag. The matcher also reads the oldest committed sequence number, so that age comparisons stay correct when sequence numbers wrap.

The matching runs as a fixed chain of request-grant-accept rounds, all in combinational logic. In each round, every still-free pipe grants to the oldest still-free lane it is compatible with. Every lane that receives one or more grants then accepts the granting pipe with the most free slots. Pairs matched in a round are removed from the free sets before the next round. The results of all rounds are merged onto two views of the same match:
- per pipe: a valid bit and the index of the lane routed to it;
- per lane: a matched bit and the index of its pipe.

Instruction payload muxing and the queue handshakes sit outside this block.

Top module: `lane_pipe_matcher`

## Requirements
- R1: A lane and a pipe are compatible only when all of the following hold: the lane is valid, the lane's class bitmask and the pipe's supported mask share at least one set bit, the pipe is ready, and the pipe's free-slot count is non-zero.
- R2: A pipe whose bypass flag is set is compatible with a lane only when both source-ready bits of that lane are 1.
- R3: When several free compatible lanes compete for a pipe, the pipe grants to the oldest of them. Lane a is older than lane b when (seq_a < seq_b) XOR (seq_a < oldest) XOR (seq_b < oldest).
- R4: Among lanes of equal age, the grant goes to the lowest lane index.
- R5: A lane granted by several pipes accepts the pipe with the largest free-slot count.
- R6: When the largest free-slot counts are equal, the lane accepts the lowest pipe index.
- R7: The match is one-to-one. When pipe_vld[p] is 1 with lane index l, lane_hit[l] is 1 with pipe index p, and the reverse also holds.
- R8: With the default number of rounds (equal to the lane count), the final match leaves no compatible lane-pipe pair in which both the lane and the pipe are unmatched.
- R9: A lane that is not matched drives lane_hit low and a pipe index of 0. A pipe that is not matched drives pipe_vld low and a lane index of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lane_vld | input | N_LANES | Lane holds an instruction |
| lane_cls | input | N_LANES*N_CLASS | Operation-class bitmask, lane l at [l*N_CLASS +: N_CLASS] |
| lane_src_rdy | input | 2*N_LANES | Source-ready bits, lane l at [2l +: 2] |
| lane_seq | input | N_LANES*SEQ_W | Sequence number per lane |
| pipe_mask | input | N_PIPES*N_CLASS | Classes each pipe supports |
| pipe_rdy | input | N_PIPES | Pipe queue is ready |
| pipe_slots | input | N_PIPES*SLOT_W | Free issue-queue slots per pipe |
| pipe_byp | input | N_PIPES | Pipe issues with no buffering |
| oldest_seq | input | SEQ_W | Oldest committed sequence number |
| pipe_vld | output | N_PIPES | Pipe received a lane |
| pipe_lane | output | N_PIPES*LANE_IW | Lane index routed to each pipe |
| lane_hit | output | N_LANES | Lane was matched |
| lane_pipe | output | N_LANES*PIPE_IW | Pipe index of each lane |

## Verification
In the same evaluation, the age-based grant and the slot-based accept can pull in opposite directions. Several pipes grant the same oldest lane, that lane accepts only one of them, and the pipes it turned down must find a younger lane in a later round. The vector table provokes this with uniform lanes against pipes of differing depth, and with two pipes of equal depth that grant the same lane. Each case is judged against a match worked out by hand, round by round, from the requirements, together with the one-to-one relation between the pipe and lane views.

// File: rtl/lpm_pkg.sv
// Package: shared helpers for the lane-to-pipe matcher.
// Assumes sequence numbers are at most 32 bits wide and that all in-flight
// numbers lie within half the sequence space of the oldest committed one.
package lpm_pkg;

    localparam int SEQ_MAX_W = 32;

    // True when sequence a is older than sequence b, relative to oldest o.
    function automatic logic seq_older(input logic [SEQ_MAX_W-1:0] a,
                                       input logic [SEQ_MAX_W-1:0] b,
                                       input logic [SEQ_MAX_W-1:0] o);
        return (a < b) ^ (a < o) ^ (b < o);
    endfunction

endpackage

// File: rtl/lpm_compat.sv
// Module: lpm_compat
// Builds the lane x pipe compatibility matrix, bit l*N_PIPES+p.
// Assumes a lane may carry several class bits; any overlap with the pipe's
// mask counts. Bypass pipes additionally need both sources of the lane ready.
module lpm_compat #(
    parameter int N_LANES = 4,
    parameter int N_PIPES = 3,
    parameter int N_CLASS = 4,
    parameter int SLOT_W  = 3
) (
    input  logic [N_LANES-1:0]         lane_vld,
    input  logic [N_LANES*N_CLASS-1:0] lane_cls,
    input  logic [2*N_LANES-1:0]       lane_src_rdy,
    input  logic [N_PIPES*N_CLASS-1:0] pipe_mask,
    input  logic [N_PIPES-1:0]         pipe_rdy,
    input  logic [N_PIPES*SLOT_W-1:0]  pipe_slots,
    input  logic [N_PIPES-1:0]         pipe_byp,
    output logic [N_LANES*N_PIPES-1:0] compat
);
    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        for (genvar p = 0; p < N_PIPES; p++) begin : g_pipe
            logic cls_ok, pipe_ok, src_ok;
            // Class overlap between the lane's operation and the pipe's subset.
            assign cls_ok  = |(lane_cls[l*N_CLASS +: N_CLASS] & pipe_mask[p*N_CLASS +: N_CLASS]);
            // Pipe can take an instruction this cycle.
            assign pipe_ok = pipe_rdy[p] && (pipe_slots[p*SLOT_W +: SLOT_W] != '0);
            // Bypass pipes only take lanes whose operands are all ready.
            assign src_ok  = !pipe_byp[p] || (&lane_src_rdy[2*l +: 2]);
            assign compat[l*N_PIPES + p] = lane_vld[l] && cls_ok && pipe_ok && src_ok;
        end
    end
endmodule

// File: rtl/lpm_grant.sv
// Module: lpm_grant
// One pipe's grant arbiter: picks the oldest requesting lane.
// Assumes the age order is consistent across requesters; equal ages keep
// the lower lane index because only a strictly older lane displaces it.
module lpm_grant #(
    parameter int N_LANES = 4,
    parameter int SEQ_W   = 6,
    localparam int LANE_IW = (N_LANES > 1) ? $clog2(N_LANES) : 1
) (
    input  logic [N_LANES-1:0]       req,
    input  logic [N_LANES*SEQ_W-1:0] seq,
    input  logic [SEQ_W-1:0]         oldest,
    output logic [N_LANES-1:0]       gnt
);
    logic [LANE_IW-1:0] best;
    logic               found;

    // Ascending scan keeping the oldest requester seen so far.
    always_comb begin
        found = 1'b0;
        best  = '0;
        for (int i = 0; i < N_LANES; i++) begin
            if (req[i] && (!found ||
                lpm_pkg::seq_older(32'(seq[i*SEQ_W +: SEQ_W]),
                                   32'(seq[best*SEQ_W +: SEQ_W]),
                                   32'(oldest)))) begin
                found = 1'b1;
                best  = i[LANE_IW-1:0];
            end
        end
        gnt = '0;
        if (found) gnt[best] = 1'b1;
    end
endmodule

// File: rtl/lpm_accept.sv
// Module: lpm_accept
// One lane's accept arbiter: picks the granting pipe with the most slots.
// Assumes slot counts are unsigned; ties keep the lower pipe index.
module lpm_accept #(
    parameter int N_PIPES = 3,
    parameter int SLOT_W  = 3,
    localparam int PIPE_IW = (N_PIPES > 1) ? $clog2(N_PIPES) : 1
) (
    input  logic [N_PIPES-1:0]        gnt,
    input  logic [N_PIPES*SLOT_W-1:0] slots,
    output logic [N_PIPES-1:0]        acc
);
    logic [PIPE_IW-1:0] best;
    logic               found;

    // Ascending scan keeping the deepest granting pipe seen so far.
    always_comb begin
        found = 1'b0;
        best  = '0;
        for (int p = 0; p < N_PIPES; p++) begin
            if (gnt[p] && (!found ||
                slots[p*SLOT_W +: SLOT_W] > slots[best*SLOT_W +: SLOT_W])) begin
                found = 1'b1;
                best  = p[PIPE_IW-1:0];
            end
        end
        acc = '0;
        if (found) acc[best] = 1'b1;
    end
endmodule

// File: rtl/lpm_iter.sv
// Module: lpm_iter
// One request-grant-accept round over the lanes and pipes still free.
// Assumes compat already holds every static compatibility condition.
// Outputs this round's match matrix and the free masks for the next round.
module lpm_iter #(
    parameter int N_LANES = 4,
    parameter int N_PIPES = 3,
    parameter int SEQ_W   = 6,
    parameter int SLOT_W  = 3
) (
    input  logic [N_LANES*N_PIPES-1:0] compat,
    input  logic [N_LANES-1:0]         lane_free_i,
    input  logic [N_PIPES-1:0]         pipe_free_i,
    input  logic [N_LANES*SEQ_W-1:0]   lane_seq,
    input  logic [SEQ_W-1:0]           oldest_seq,
    input  logic [N_PIPES*SLOT_W-1:0]  pipe_slots,
    output logic [N_LANES*N_PIPES-1:0] match,
    output logic [N_LANES-1:0]         lane_free_o,
    output logic [N_PIPES-1:0]         pipe_free_o
);
    logic [N_LANES-1:0] col_req [N_PIPES];
    logic [N_LANES-1:0] col_gnt [N_PIPES];
    logic [N_PIPES-1:0] row_gnt [N_LANES];
    logic [N_PIPES-1:0] row_acc [N_LANES];
    logic [N_LANES-1:0] col_acc [N_PIPES];

    // Transpose between per-pipe columns and per-lane rows.
    for (genvar l = 0; l < N_LANES; l++) begin : g_xl
        for (genvar p = 0; p < N_PIPES; p++) begin : g_xp
            assign col_req[p][l] = compat[l*N_PIPES + p] && lane_free_i[l] && pipe_free_i[p];
            assign row_gnt[l][p] = col_gnt[p][l];
            assign col_acc[p][l] = row_acc[l][p];
            assign match[l*N_PIPES + p] = row_acc[l][p];
        end
    end

    // Grant phase: one age arbiter per pipe.
    for (genvar p = 0; p < N_PIPES; p++) begin : g_grant
        lpm_grant #(.N_LANES(N_LANES), .SEQ_W(SEQ_W)) u_grant (
            .req    (col_req[p]),
            .seq    (lane_seq),
            .oldest (oldest_seq),
            .gnt    (col_gnt[p])
        );
        assign pipe_free_o[p] = pipe_free_i[p] && !(|col_acc[p]);
    end

    // Accept phase: one slot arbiter per lane.
    for (genvar l = 0; l < N_LANES; l++) begin : g_accept
        lpm_accept #(.N_PIPES(N_PIPES), .SLOT_W(SLOT_W)) u_accept (
            .gnt   (row_gnt[l]),
            .slots (pipe_slots),
            .acc   (row_acc[l])
        );
        assign lane_free_o[l] = lane_free_i[l] && !(|row_acc[l]);
    end
endmodule

// File: rtl/lane_pipe_matcher.sv
// Module: lane_pipe_matcher (top)
// Combinational one-to-one matcher from frontend lanes to backend pipes,
// built as N_ITER chained grant/accept rounds. Holds no state, so it has no
// clock or reset. Assumes SEQ_W <= 32 and N_ITER >= 1.
module lane_pipe_matcher #(
    parameter int N_LANES = 4,
    parameter int N_PIPES = 3,
    parameter int N_CLASS = 4,
    parameter int SEQ_W   = 6,
    parameter int SLOT_W  = 3,
    parameter int N_ITER  = N_LANES,
    localparam int LANE_IW = (N_LANES > 1) ? $clog2(N_LANES) : 1,
    localparam int PIPE_IW = (N_PIPES > 1) ? $clog2(N_PIPES) : 1
) (
    input  logic [N_LANES-1:0]         lane_vld,
    input  logic [N_LANES*N_CLASS-1:0] lane_cls,
    input  logic [2*N_LANES-1:0]       lane_src_rdy,
    input  logic [N_LANES*SEQ_W-1:0]   lane_seq,
    input  logic [N_PIPES*N_CLASS-1:0] pipe_mask,
    input  logic [N_PIPES-1:0]         pipe_rdy,
    input  logic [N_PIPES*SLOT_W-1:0]  pipe_slots,
    input  logic [N_PIPES-1:0]         pipe_byp,
    input  logic [SEQ_W-1:0]           oldest_seq,
    output logic [N_PIPES-1:0]         pipe_vld,
    output logic [N_PIPES*LANE_IW-1:0] pipe_lane,
    output logic [N_LANES-1:0]         lane_hit,
    output logic [N_LANES*PIPE_IW-1:0] lane_pipe
);
    localparam int N_PAIR = N_LANES * N_PIPES;

    logic [N_PAIR-1:0]  compat;
    logic [N_LANES-1:0] lfree [N_ITER+1];
    logic [N_PIPES-1:0] pfree [N_ITER+1];
    logic [N_PAIR-1:0]  rmatch [N_ITER];
    logic [N_PAIR-1:0]  match_all;

    lpm_compat #(
        .N_LANES(N_LANES), .N_PIPES(N_PIPES), .N_CLASS(N_CLASS), .SLOT_W(SLOT_W)
    ) u_compat (
        .lane_vld     (lane_vld),
        .lane_cls     (lane_cls),
        .lane_src_rdy (lane_src_rdy),
        .pipe_mask    (pipe_mask),
        .pipe_rdy     (pipe_rdy),
        .pipe_slots   (pipe_slots),
        .pipe_byp     (pipe_byp),
        .compat       (compat)
    );

    assign lfree[0] = '1;
    assign pfree[0] = '1;

    // Chain of matching rounds, each seeing the leftovers of the previous one.
    for (genvar k = 0; k < N_ITER; k++) begin : g_round
        lpm_iter #(
            .N_LANES(N_LANES), .N_PIPES(N_PIPES), .SEQ_W(SEQ_W), .SLOT_W(SLOT_W)
        ) u_iter (
            .compat      (compat),
            .lane_free_i (lfree[k]),
            .pipe_free_i (pfree[k]),
            .lane_seq    (lane_seq),
            .oldest_seq  (oldest_seq),
            .pipe_slots  (pipe_slots),
            .match       (rmatch[k]),
            .lane_free_o (lfree[k+1]),
            .pipe_free_o (pfree[k+1])
        );
    end

    // OR of every round's matches.
    always_comb begin
        match_all = '0;
        for (int k = 0; k < N_ITER; k++) match_all |= rmatch[k];
    end

    // Whatever left the free sets got matched.
    assign lane_hit = ~lfree[N_ITER];
    assign pipe_vld = ~pfree[N_ITER];

    // Encode the one-hot match matrix into the two index views.
    always_comb begin
        pipe_lane = '0;
        lane_pipe = '0;
        for (int l = 0; l < N_LANES; l++) begin
            for (int p = 0; p < N_PIPES; p++) begin
                if (match_all[l*N_PIPES + p]) begin
                    pipe_lane[p*LANE_IW +: LANE_IW] |= l[LANE_IW-1:0];
                    lane_pipe[l*PIPE_IW +: PIPE_IW] |= p[PIPE_IW-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/lpm_checker.sv
// Module: lpm_checker
// Property checks on the matcher's ports, bound into every instance.
// Assumes inputs settle between evaluations; checks are skipped while any
// observed value is unknown.
module lpm_checker #(
    parameter int N_LANES = 4,
    parameter int N_PIPES = 3,
    parameter int N_CLASS = 4,
    parameter int SLOT_W  = 3,
    parameter int N_ITER  = N_LANES,
    localparam int LANE_IW = (N_LANES > 1) ? $clog2(N_LANES) : 1,
    localparam int PIPE_IW = (N_PIPES > 1) ? $clog2(N_PIPES) : 1
) (
    input logic [N_LANES-1:0]         lane_vld,
    input logic [N_LANES*N_CLASS-1:0] lane_cls,
    input logic [2*N_LANES-1:0]       lane_src_rdy,
    input logic [N_PIPES*N_CLASS-1:0] pipe_mask,
    input logic [N_PIPES-1:0]         pipe_rdy,
    input logic [N_PIPES*SLOT_W-1:0]  pipe_slots,
    input logic [N_PIPES-1:0]         pipe_byp,
    input logic [N_PIPES-1:0]         pipe_vld,
    input logic [N_PIPES*LANE_IW-1:0] pipe_lane,
    input logic [N_LANES-1:0]         lane_hit,
    input logic [N_LANES*PIPE_IW-1:0] lane_pipe
);
    // Independent compatibility model from the requirement text.
    function automatic logic pair_ok(input int l, input int p);
        return lane_vld[l] && pipe_rdy[p]
            && (|(lane_cls[l*N_CLASS +: N_CLASS] & pipe_mask[p*N_CLASS +: N_CLASS]))
            && (pipe_slots[p*SLOT_W +: SLOT_W] != '0)
            && (!pipe_byp[p] || lane_src_rdy[2*l] && lane_src_rdy[2*l+1]);
    endfunction

    logic known;
    assign known = !$isunknown({lane_vld, lane_cls, lane_src_rdy, pipe_mask, pipe_rdy,
                                pipe_slots, pipe_byp, pipe_vld, pipe_lane, lane_hit, lane_pipe});

    // Per-pipe checks: inverse mapping and idle index.
    always_comb begin
        if (known) begin
            for (int p = 0; p < N_PIPES; p++) begin
                // R7
                pipe_to_lane_chk: assert (!pipe_vld[p] ||
                    (lane_hit[pipe_lane[p*LANE_IW +: LANE_IW]] &&
                     lane_pipe[pipe_lane[p*LANE_IW +: LANE_IW]*PIPE_IW +: PIPE_IW] == p[PIPE_IW-1:0]));
                // R9
                idle_pipe_index_chk: assert (pipe_vld[p] || pipe_lane[p*LANE_IW +: LANE_IW] == '0);
            end
        end
    end

    // Per-lane checks: inverse mapping, legality of the pair, idle index.
    always_comb begin
        if (known) begin
            for (int l = 0; l < N_LANES; l++) begin
                // R7
                lane_to_pipe_chk: assert (!lane_hit[l] ||
                    (pipe_vld[lane_pipe[l*PIPE_IW +: PIPE_IW]] &&
                     pipe_lane[lane_pipe[l*PIPE_IW +: PIPE_IW]*LANE_IW +: LANE_IW] == l[LANE_IW-1:0]));
                // R1 R2
                legal_pair_chk: assert (!lane_hit[l] ||
                    pair_ok(l, int'(lane_pipe[l*PIPE_IW +: PIPE_IW])));
                // R9
                idle_lane_index_chk: assert (lane_hit[l] || lane_pipe[l*PIPE_IW +: PIPE_IW] == '0);
            end
        end
    end

    // Maximality once enough rounds are configured.
    always_comb begin
        if (known && N_ITER >= N_LANES) begin
            for (int l = 0; l < N_LANES; l++) begin
                for (int p = 0; p < N_PIPES; p++) begin
                    // R8
                    no_leftover_pair_chk: assert (lane_hit[l] || pipe_vld[p] || !pair_ok(l, p));
                end
            end
        end
    end
endmodule

bind lane_pipe_matcher lpm_checker #(
    .N_LANES(N_LANES), .N_PIPES(N_PIPES), .N_CLASS(N_CLASS),
    .SLOT_W(SLOT_W), .N_ITER(N_ITER)
) u_lpm_chk (
    .lane_vld     (lane_vld),
    .lane_cls     (lane_cls),
    .lane_src_rdy (lane_src_rdy),
    .pipe_mask    (pipe_mask),
    .pipe_rdy     (pipe_rdy),
    .pipe_slots   (pipe_slots),
    .pipe_byp     (pipe_byp),
    .pipe_vld     (pipe_vld),
    .pipe_lane    (pipe_lane),
    .lane_hit     (lane_hit),
    .lane_pipe    (lane_pipe)
);

// File: tb/tb_lane_pipe_matcher.sv
// Bench for lane_pipe_matcher with 4 lanes, 3 pipes, 4 classes, 6-bit
// sequence numbers and 3-bit slot counts. Class bits: 0 alu, 1 mul, 2 mem,
// 3 ctrl. Packed fields list the highest lane/pipe first.
module tb_lane_pipe_matcher;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [3:0]  lane_vld;
    logic [15:0] lane_cls;
    logic [7:0]  lane_src_rdy;
    logic [23:0] lane_seq;
    logic [11:0] pipe_mask;
    logic [2:0]  pipe_rdy;
    logic [8:0]  pipe_slots;
    logic [2:0]  pipe_byp;
    logic [5:0]  oldest_seq;
    logic [2:0]  pipe_vld;
    logic [5:0]  pipe_lane;
    logic [3:0]  lane_hit;
    logic [7:0]  lane_pipe;

    lane_pipe_matcher #(
        .N_LANES(4), .N_PIPES(3), .N_CLASS(4), .SEQ_W(6), .SLOT_W(3)
    ) dut (.*);

    typedef struct packed {
        logic [3:0]  vld;
        logic [15:0] cls;
        logic [7:0]  src;
        logic [23:0] seq;
        logic [11:0] pmask;
        logic [2:0]  prdy;
        logic [8:0]  pslots;
        logic [2:0]  pbyp;
        logic [5:0]  old;
        logic [2:0]  e_pvld;
        logic [5:0]  e_plane;
        logic [3:0]  e_hit;
        logic [7:0]  e_lpipe;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t TBL [NV] = '{
        // uniform lanes, pipes 2/5/3 slots: three rounds, deepest pipe to the oldest
        '{4'b1111, {4{4'h1}}, 8'hFF, {6'd3,6'd2,6'd1,6'd0}, {3{4'h1}}, 3'b111,
          {3'd3,3'd5,3'd2}, 3'b000, 6'd0,
          3'b111, {2'd1,2'd0,2'd2}, 4'b0111, {2'd0,2'd0,2'd2,2'd1}},
        // wrapped sequence numbers: lane1 (61) oldest relative to 60
        '{4'b1111, {4{4'h1}}, 8'hFF, {6'd0,6'd63,6'd61,6'd2}, {3{4'h1}}, 3'b001,
          {3'd0,3'd0,3'd4}, 3'b000, 6'd60,
          3'b001, {2'd0,2'd0,2'd1}, 4'b0010, 8'h00},
        // equal ages on lanes 1 and 3
        '{4'b1110, {4{4'h1}}, 8'hFF, {6'd5,6'd9,6'd5,6'd0}, {3{4'h1}}, 3'b100,
          {3'd1,3'd0,3'd0}, 3'b000, 6'd0,
          3'b100, {2'd1,2'd0,2'd0}, 4'b0010, {2'd0,2'd0,2'd2,2'd0}},
        // equal-slot grants, class mismatch, empty pipe
        '{4'b1111, {4'h1,4'h4,4'h2,4'h1}, 8'hFF, {6'd3,6'd2,6'd1,6'd0}, {4'h4,4'h1,4'h3}, 3'b111,
          {3'd0,3'd3,3'd3}, 3'b000, 6'd0,
          3'b011, {2'd0,2'd3,2'd0}, 4'b1001, {2'd1,2'd0,2'd0,2'd0}},
        // bypass pipe 0 refuses lane 0 with one source pending
        '{4'b0011, {4'h0,4'h0,4'h8,4'h8}, 8'b0000_1110, {6'd0,6'd0,6'd1,6'd0}, {4'h0,4'h9,4'h8}, 3'b011,
          {3'd0,3'd2,3'd1}, 3'b001, 6'd0,
          3'b011, {2'd0,2'd0,2'd1}, 4'b0011, {2'd0,2'd0,2'd0,2'd1}},
        // pipe 1 not ready
        '{4'b1111, {4{4'h1}}, 8'hFF, {6'd13,6'd12,6'd11,6'd10}, {3{4'h1}}, 3'b101,
          {3'd7,3'd5,3'd1}, 3'b000, 6'd10,
          3'b101, {2'd0,2'd0,2'd1}, 4'b0011, {2'd0,2'd0,2'd0,2'd2}},
        // no valid lanes
        '{4'b0000, {4{4'h1}}, 8'hFF, 24'd0, {3{4'h1}}, 3'b111,
          {3'd4,3'd4,3'd4}, 3'b000, 6'd0,
          3'b000, 6'd0, 4'b0000, 8'h00}
    };
    localparam string TAG [NV] = '{"R5 R8", "R3", "R4", "R6 R1", "R2", "R1", "R9"};

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(posedge clk);
        lane_vld     = v.vld;
        lane_cls     = v.cls;
        lane_src_rdy = v.src;
        lane_seq     = v.seq;
        pipe_mask    = v.pmask;
        pipe_rdy     = v.prdy;
        pipe_slots   = v.pslots;
        pipe_byp     = v.pbyp;
        oldest_seq   = v.old;
        @(negedge clk);
    endtask

    initial begin
        // Idle state: no lanes, no pipes ready (R9).
        apply('0);
        check("R9", "pipe_vld idle", 32'(pipe_vld), 0);
        check("R9", "pipe_lane idle", 32'(pipe_lane), 0);
        check("R9", "lane_hit idle", 32'(lane_hit), 0);
        check("R9", "lane_pipe idle", 32'(lane_pipe), 0);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            check(TAG[i], "pipe_vld",  32'(pipe_vld),  32'(TBL[i].e_pvld));
            check(TAG[i], "pipe_lane", 32'(pipe_lane), 32'(TBL[i].e_plane));
            check(TAG[i], "lane_hit",  32'(lane_hit),  32'(TBL[i].e_hit));
            check(TAG[i], "lane_pipe", 32'(lane_pipe), 32'(TBL[i].e_lpipe));
            // R7: both views count the same number of pairs
            check("R7", "match count", 32'($countones(pipe_vld)), 32'($countones(lane_hit)));
        end

        // Directed: all pipes bypass, every lane has a pending source (R2).
        begin
            vec_t v;
            v = TBL[0];
            v.pbyp = 3'b111;
            v.src  = 8'b0110_1001;
            apply(v);
            check("R2", "bypass blocks all", 32'(pipe_vld), 0);
            check("R9", "bypass idle lane_pipe", 32'(lane_pipe), 0);
        end

        // Directed: same ages everywhere, one pipe; lowest lane wins (R4).
        begin
            vec_t v;
            v = TBL[0];
            v.seq  = {4{6'd33}};
            v.prdy = 3'b010;
            apply(v);
            check("R4", "tie lane index", 32'(pipe_lane), 32'({2'd0,2'd0,2'd0}));
            check("R4", "tie lane hit", 32'(lane_hit), 32'(4'b0001));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule